// File: doc/BRIEF.md
# Folded Symmetric FIR Turnaround Path

This block is the data-path core of a symmetric FIR filter that uses folding. Each sample accepted on a valid strobe enters a forward chain of delay elements. At the far end, a turnaround multiplexer sends it back through a reverse chain of the same number of elements. Each tap pair lines up one forward sample with one reverse sample. The two are summed in a pre-adder that is one bit wider than a sample, and the sum is weighted by that pair's signed coefficient. A single registered stage accumulates the products of all pairs.

The length of every delay element is set at run time, counted in accepted samples. Interleaved streams are handled by setting this length to the number of interleaved channels. Two configuration levels control the tap count. One selects an even or an odd count. The other enables odd-tap interleave. Together they decide which point of the forward chain feeds the reverse chain. With an odd count, the centre sample reaches both operands of the last pair, so it is counted twice. For this reason the centre coefficient has to be loaded at half its nominal value.

Top module: `fold_fir_turn`

## Requirements
- R1: When `in_valid` is low, neither chain shifts: `fwd_ops` and `rev_ops` keep their values, whatever `in_sample` does.
- R2: With effective length L, forward operand k (bits k*W upward, k = 0..P-1, where P is half the tap count) equals the ((k+1)*L)-th most recent accepted sample (1 = newest).
- R3: With `cfg_odd` = 0 (even tap count), reverse operand k equals the ((2P-k)*L)-th most recent accepted sample, and `cfg_ilv` has no effect.
- R4: With `cfg_odd` = 1 and `cfg_ilv` = 1 (odd-tap interleave), reverse operand k equals the ((2P-1-k)*L)-th most recent sample. Both operands of pair P-1 therefore carry the same centre sample.
- R5: With `cfg_odd` = 1 and `cfg_ilv` = 0 (plain odd), the reverse chain is fed with the sample about to leave the last forward element. Reverse operand k then equals the ((2P-k)*L-1)-th most recent sample, so the centre is aligned on pair P-1 when L = 1.
- R6: A `cfg_len` of 0 acts as 1, and a value above MAXLEN acts as MAXLEN.
- R7: When `coef_we` is high at a clock edge, the signed `coef_data` is stored as the coefficient of pair `coef_addr`.
- R8: Two clock edges after a strobe, `acc_out` equals the sum over pairs k of (forward_k + reverse_k) * coef_k, computed in signed arithmetic at full precision on the operands left by that strobe, and `acc_valid` is high for that cycle.
- R9: While `acc_valid` is low, `acc_out` holds its value.
- R10: Reset clears both chains, all coefficients, `acc_out` and `acc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe; the chains shift only on it |
| in_sample | input | W (12) | Signed input sample |
| cfg_odd | input | 1 | 0 = even tap count, 1 = odd tap count |
| cfg_ilv | input | 1 | 1 = odd-tap interleave (used only when cfg_odd = 1) |
| cfg_len | input | LENW (3) | Length of each delay element, in samples |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | AW (2) | Pair index of the coefficient being written |
| coef_data | input | CW (10) | Signed coefficient value |
| fwd_ops | output | P*W (48) | Forward operand of each pair, pair k at bits k*W |
| rev_ops | output | P*W (48) | Reverse operand of each pair, pair k at bits k*W |
| acc_out | output | ACCW (25) | Sum of the weighted pre-adder results |
| acc_valid | output | 1 | acc_out updated this cycle |

## Verification
The bench builds the block with 8 taps (four pairs), 12-bit samples, 10-bit coefficients and a maximum element length of 4. It keeps a 3-bit length field. With four pairs, pairs in the middle of the chains sit between the head and the turnaround, so every branch of the turnaround is exercised. Lengths 1 to 4 let the plain odd mode be run both where its centre aligns and where it does not. The spare codes 0, 5, 6 and 7 reach the clamping. Full-scale positive and negative samples against extreme coefficients push the pre-adders and the accumulator to their widest values.

// File: rtl/fold_pkg.sv
package fold_pkg;

  // Source chosen for the first reverse element
  typedef enum logic [1:0] {
    TURN_EVEN     = 2'd0,  // output of the last forward element
    TURN_ODD_NEXT = 2'd1,  // sample about to leave the last forward element
    TURN_ODD_ILV  = 2'd2   // output of the next-to-last forward element
  } turn_t;

  function automatic turn_t pick_turn(input logic odd, input logic ilv);
    if (!odd) return TURN_EVEN;
    if (ilv) return TURN_ODD_ILV;
    return TURN_ODD_NEXT;
  endfunction

  // Length requests outside 1..maxlen are pulled to the nearest legal value
  function automatic int clamp_len(input int raw, input int maxlen);
    if (raw < 1) return 1;
    if (raw > maxlen) return maxlen;
    return raw;
  endfunction

endpackage

// File: rtl/fold_delay.sv
module fold_delay #(
  parameter int W      = 12,
  parameter int MAXLEN = 4,
  parameter int LENW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [LENW-1:0] len,
  input  logic [W-1:0]    d,
  output logic [W-1:0]    q,
  output logic [W-1:0]    q_next
);

  logic [W-1:0] stage [MAXLEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXLEN; i++) stage[i] <= '0;
    end else if (en) begin
      stage[0] <= d;
      for (int i = 1; i < MAXLEN; i++) stage[i] <= stage[i-1];
    end
  end

  // Output tap at depth len; q_next is what q becomes on the next strobe
  always_comb begin
    q      = '0;
    q_next = d;
    for (int i = 0; i < MAXLEN; i++)
      if (LENW'(i + 1) == len) q = stage[i];
    for (int i = 0; i < MAXLEN - 1; i++)
      if (LENW'(i + 2) == len) q_next = stage[i];
  end

  // R2: a strobe moves the announced next value onto the output
  a_r2_stage_advance: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (!$stable(len) || q == $past(q_next)));

endmodule

// File: rtl/fold_turn.sv
module fold_turn #(
  parameter int W = 12
) (
  input  fold_pkg::turn_t sel,
  input  logic [W-1:0]    last_q,
  input  logic [W-1:0]    last_next,
  input  logic [W-1:0]    prev_q,
  output logic [W-1:0]    r0_src
);

  always_comb begin
    unique case (sel)
      fold_pkg::TURN_EVEN:     r0_src = last_q;
      fold_pkg::TURN_ODD_NEXT: r0_src = last_next;
      fold_pkg::TURN_ODD_ILV:  r0_src = prev_q;
      default:                 r0_src = last_q;
    endcase
  end

endmodule

// File: rtl/fold_mac.sv
module fold_mac #(
  parameter int P    = 4,
  parameter int W    = 12,
  parameter int CW   = 10,
  parameter int AW   = 2,
  parameter int ACCW = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             coef_we,
  input  logic [AW-1:0]    coef_addr,
  input  logic [CW-1:0]    coef_data,
  input  logic [P*W-1:0]   fwd_ops,
  input  logic [P*W-1:0]   rev_ops,
  output logic [ACCW-1:0]  acc_out,
  output logic             acc_valid
);

  localparam int PW = W + 1 + CW;

  logic signed [CW-1:0]   coef [P];
  logic signed [ACCW-1:0] term;
  logic signed [ACCW-1:0] mac_sum;

  // Pre-adder: one guard bit so a sum of two full-scale samples cannot wrap
  function automatic logic signed [W:0] presum(input logic signed [W-1:0] a,
                                               input logic signed [W-1:0] b);
    logic signed [W:0] ea;
    logic signed [W:0] eb;
    ea = a;
    eb = b;
    return ea + eb;
  endfunction

  function automatic logic signed [PW-1:0] weigh(input logic signed [W:0]    s,
                                                 input logic signed [CW-1:0] c);
    logic signed [PW-1:0] es;
    logic signed [PW-1:0] ec;
    es = s;
    ec = c;
    return es * ec;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < P; k++) coef[k] <= '0;
    end else begin
      for (int k = 0; k < P; k++)
        if (coef_we && coef_addr == AW'(k)) coef[k] <= coef_data;
    end
  end

  always_comb begin
    mac_sum = '0;
    term    = '0;
    for (int k = 0; k < P; k++) begin
      term    = weigh(presum($signed(fwd_ops[k*W +: W]), $signed(rev_ops[k*W +: W])), coef[k]);
      mac_sum = mac_sum + term;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out   <= '0;
      acc_valid <= 1'b0;
    end else begin
      acc_valid <= step;
      if (step) acc_out <= mac_sum;
    end
  end

  // R9: result only moves in a cycle flagged valid
  a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> $stable(acc_out));

endmodule

// File: rtl/fold_fir_turn.sv
module fold_fir_turn #(
  parameter  int TAPS   = 8,
  parameter  int W      = 12,
  parameter  int CW     = 10,
  parameter  int MAXLEN = 4,
  localparam int P      = TAPS / 2,
  localparam int LENW   = $clog2(MAXLEN + 1),
  localparam int AW     = (P > 1) ? $clog2(P) : 1,
  localparam int ACCW   = W + 1 + CW + $clog2(P)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W-1:0]    in_sample,
  input  logic            cfg_odd,
  input  logic            cfg_ilv,
  input  logic [LENW-1:0] cfg_len,
  input  logic            coef_we,
  input  logic [AW-1:0]   coef_addr,
  input  logic [CW-1:0]   coef_data,
  output logic [P*W-1:0]  fwd_ops,
  output logic [P*W-1:0]  rev_ops,
  output logic [ACCW-1:0] acc_out,
  output logic            acc_valid
);

  logic [LENW-1:0]         len_eff;
  fold_pkg::turn_t         turn_sel;
  logic [P-1:0][W-1:0]     fwd_q;
  logic [P-1:0][W-1:0]     fwd_nx;
  logic [P-1:0][W-1:0]     rev_q;
  logic [P-1:0][W-1:0]     rev_nx;
  logic [W-1:0]            prev_src;
  logic [W-1:0]            r0_src;
  logic                    step;

  assign len_eff  = LENW'(fold_pkg::clamp_len(int'(cfg_len), MAXLEN));
  assign turn_sel = fold_pkg::pick_turn(cfg_odd, cfg_ilv);

  // Forward chain
  for (genvar k = 0; k < P; k++) begin : g_fwd
    logic [W-1:0] din;
    if (k == 0) begin : g_head
      assign din = in_sample;
    end else begin : g_link
      assign din = fwd_q[k-1];
    end
    fold_delay #(.W(W), .MAXLEN(MAXLEN), .LENW(LENW)) u_elem (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .len(len_eff),
      .d(din), .q(fwd_q[k]), .q_next(fwd_nx[k]));
  end

  if (P > 1) begin : g_prev_chain
    assign prev_src = fwd_q[P-2];
  end else begin : g_prev_input
    assign prev_src = in_sample;
  end

  fold_turn #(.W(W)) u_turn (
    .sel(turn_sel), .last_q(fwd_q[P-1]), .last_next(fwd_nx[P-1]),
    .prev_q(prev_src), .r0_src(r0_src));

  // Reverse chain
  for (genvar j = 0; j < P; j++) begin : g_rev
    logic [W-1:0] din;
    if (j == 0) begin : g_head
      assign din = r0_src;
    end else begin : g_link
      assign din = rev_q[j-1];
    end
    fold_delay #(.W(W), .MAXLEN(MAXLEN), .LENW(LENW)) u_elem (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .len(len_eff),
      .d(din), .q(rev_q[j]), .q_next(rev_nx[j]));
  end

  // Pair k: forward element k with reverse element P-1-k
  assign fwd_ops = fwd_q;
  for (genvar k = 0; k < P; k++) begin : g_pair
    assign rev_ops[k*W +: W] = rev_q[P-1-k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= 1'b0;
    else        step <= in_valid;
  end

  fold_mac #(.P(P), .W(W), .CW(CW), .AW(AW), .ACCW(ACCW)) u_mac (
    .clk(clk), .rst_n(rst_n), .step(step),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .fwd_ops(fwd_ops), .rev_ops(rev_ops),
    .acc_out(acc_out), .acc_valid(acc_valid));

  // Strobes seen under the current, unbroken configuration
  logic [LENW+1:0] cur_cfg;
  logic [LENW+1:0] prev_cfg;
  logic [LENW-1:0] settle_cnt;
  logic            cfg_changed;
  logic            centre_armed;

  assign cur_cfg     = {cfg_odd, cfg_ilv, len_eff};
  assign cfg_changed = (cur_cfg != prev_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cfg   <= '0;
      settle_cnt <= '0;
    end else begin
      prev_cfg <= cur_cfg;
      if (cfg_changed)
        settle_cnt <= in_valid ? LENW'(1) : '0;
      else if (in_valid && settle_cnt != LENW'(MAXLEN))
        settle_cnt <= settle_cnt + LENW'(1);
    end
  end

  assign centre_armed = cfg_odd && (cfg_ilv || len_eff == LENW'(1)) &&
                        !cfg_changed && (settle_cnt >= len_eff);

  // R1: no strobe, no movement on either chain
  a_r1_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(fwd_ops) && $stable(rev_ops)));

  // R3: every element of both chains takes its announced next value
  a_r3_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!$stable(len_eff) ||
                  (fwd_q == $past(fwd_nx) && rev_q == $past(rev_nx))));

  // R4 / R5: centre sample on both operands of the last pair
  a_r4_centre: assert property (@(posedge clk) disable iff (!rst_n)
    centre_armed |-> (fwd_q[P-1] == rev_q[0]));

  // R8: result flagged two edges after a strobe
  a_r8_acc_timing: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 acc_valid);

endmodule

// File: tb/tb_fold_fir_turn.sv
module tb_fold_fir_turn;

  localparam int CLK_PERIOD = 10;
  localparam int TAPS   = 8;
  localparam int W      = 12;
  localparam int CW     = 10;
  localparam int MAXLEN = 4;
  localparam int P      = TAPS / 2;
  localparam int LENW   = $clog2(MAXLEN + 1);
  localparam int AW     = (P > 1) ? $clog2(P) : 1;
  localparam int ACCW   = W + 1 + CW + $clog2(P);
  localparam int HDEPTH = 64;
  localparam int NCFG   = 9;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [W-1:0]    in_sample;
  logic            cfg_odd;
  logic            cfg_ilv;
  logic [LENW-1:0] cfg_len;
  logic            coef_we;
  logic [AW-1:0]   coef_addr;
  logic [CW-1:0]   coef_data;
  logic [P*W-1:0]  fwd_ops;
  logic [P*W-1:0]  rev_ops;
  logic [ACCW-1:0] acc_out;
  logic            acc_valid;

  fold_fir_turn #(.TAPS(TAPS), .W(W), .CW(CW), .MAXLEN(MAXLEN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_odd(cfg_odd), .cfg_ilv(cfg_ilv), .cfg_len(cfg_len),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .fwd_ops(fwd_ops), .rev_ops(rev_ops), .acc_out(acc_out), .acc_valid(acc_valid));

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic signed [W-1:0] hist [HDEPTH];
  int     coefv [P];
  int     mlen;
  bit     m_odd, m_ilv, m_clamped;
  longint last_acc;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Depth of the reverse operand of pair k, as stated in R3, R4 and R5
  function automatic int rev_depth(input int k);
    if (!m_odd) return (2*P - k) * mlen;
    if (m_ilv)  return (2*P - 1 - k) * mlen;
    return (2*P - k) * mlen - 1;
  endfunction

  function automatic logic [P*W-1:0] exp_fwd();
    logic [P*W-1:0] v;
    for (int k = 0; k < P; k++) v[k*W +: W] = hist[(k+1)*mlen - 1];
    return v;
  endfunction

  function automatic logic [P*W-1:0] exp_rev();
    logic [P*W-1:0] v;
    for (int k = 0; k < P; k++) v[k*W +: W] = hist[rev_depth(k) - 1];
    return v;
  endfunction

  function automatic longint exp_acc();
    longint s = 0;
    for (int k = 0; k < P; k++) begin
      longint f = longint'(hist[(k+1)*mlen - 1]);
      longint r = longint'(hist[rev_depth(k) - 1]);
      s += (f + r) * longint'(coefv[k]);
    end
    return s;
  endfunction

  function automatic longint acc_now();
    logic signed [ACCW-1:0] a;
    a = $signed(acc_out);
    return longint'(a);
  endfunction

  function automatic string rev_tag();
    if (!m_odd) return "R3 rev";
    if (m_ilv)  return "R4 rev";
    return "R5 rev";
  endfunction

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    coef_we  = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < HDEPTH; i++) hist[i] = '0;
    for (int k = 0; k < P; k++) coefv[k] = 0;
    last_acc = 0;
  endtask

  task automatic set_cfg(input bit odd, input bit ilv, input int raw);
    cfg_odd   = odd;
    cfg_ilv   = ilv;
    cfg_len   = LENW'(raw);
    m_odd     = odd;
    m_ilv     = ilv;
    m_clamped = (raw < 1) || (raw > MAXLEN);
    mlen      = (raw < 1) ? 1 : ((raw > MAXLEN) ? MAXLEN : raw);
  endtask

  task automatic load_coefs(input bit extremes);
    for (int k = 0; k < P; k++) begin
      if (extremes) coefv[k] = (k % 2 == 0) ? -(1 << (CW-1)) : (1 << (CW-1)) - 1;
      else          coefv[k] = int'($urandom % (1 << CW)) - (1 << (CW-1));
      coef_we   = 1'b1;
      coef_addr = AW'(k);
      coef_data = CW'(coefv[k]);
      @(negedge clk);
    end
    coef_we = 1'b0;
  endtask

  task automatic push(input logic [W-1:0] x, input int gap);
    in_valid  = 1'b1;
    in_sample = x;
    @(negedge clk);
    in_valid  = 1'b0;
    in_sample = W'($urandom);
    for (int i = HDEPTH - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    check(m_clamped ? "R6 fwd" : "R2 fwd", 64'(fwd_ops), 64'(exp_fwd()));
    check(rev_tag(), 64'(rev_ops), 64'(exp_rev()));
    check("R8 valid low", 64'(acc_valid), 64'(0));
    if (m_odd && (m_ilv || mlen == 1))
      check(m_ilv ? "R4 centre" : "R5 centre",
            64'(rev_ops[(P-1)*W +: W]), 64'(fwd_ops[(P-1)*W +: W]));
    @(negedge clk);
    last_acc = exp_acc();
    check("R7 R8 acc", 64'(acc_now()), 64'(last_acc));
    check("R8 valid", 64'(acc_valid), 64'(1));
    for (int g = 0; g < gap; g++) begin
      in_sample = W'($urandom);
      @(negedge clk);
      check("R1 fwd hold", 64'(fwd_ops), 64'(exp_fwd()));
      check("R1 rev hold", 64'(rev_ops), 64'(exp_rev()));
      check("R9 acc hold", 64'(acc_now()), 64'(last_acc));
    end
  endtask

  function automatic logic [W-1:0] pick_sample();
    int r = int'($urandom % 8);
    if (r == 0) return {1'b0, {(W-1){1'b1}}};
    if (r == 1) return {1'b1, {(W-1){1'b0}}};
    return W'($urandom);
  endfunction

  initial begin
    bit cfg_o [NCFG] = '{0, 0, 1, 1, 1, 0, 1, 0, 1};
    bit cfg_i [NCFG] = '{0, 1, 1, 0, 0, 0, 1, 0, 1};
    int cfg_l [NCFG] = '{1, 2, 3, 1, 2, 4, 4, 0, 7};
    void'($urandom(32'd7351));
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    coef_we = 1'b0; coef_addr = '0; coef_data = '0;
    set_cfg(0, 0, 1);
    @(negedge clk);
    do_reset();
    // R10: reset state at the ports
    check("R10 fwd", 64'(fwd_ops), 64'(0));
    check("R10 rev", 64'(rev_ops), 64'(0));
    check("R10 acc", 64'(acc_out), 64'(0));
    check("R10 valid", 64'(acc_valid), 64'(0));
    // R10: coefficients cleared, so every result is zero
    for (int n = 0; n < 6; n++) begin
      push(pick_sample(), 0);
      check("R10 coef clear", 64'(acc_out), 64'(0));
    end
    for (int c = 0; c < NCFG; c++) begin
      set_cfg(cfg_o[c], cfg_i[c], cfg_l[c]);
      do_reset();
      load_coefs(c == 0 || c == 6);
      for (int n = 0; n < 30; n++) push(pick_sample(), int'($urandom % 3));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule